// File: doc/BRIEF.md
# Microwire Serial EEPROM Target Engine

This block is the target end of a four-wire Microwire serial memory holding 64 words of 16 bits. It oversamples the chip select, serial clock and serial data lines with the system clock, finds the start bit, and collects the opcode, the address and, for writes, the data field. It then carries out single-word reads, reads that stream on through the array, single-word writes, whole-array writes, and the write enable and disable instructions. The storage is a register file. A countdown timer in system clocks stands in for self-timed programming.

Instructions with the protect-select pin high are not executed here. Their header goes out as a one-cycle command to a separate protect unit. That unit returns a per-word map, and no write reaches a word the map marks.

A host raises chip select, clocks in a frame and drops chip select. For a write, the falling chip select starts programming. The next frame then only shows ready or busy on the data output until programming ends.

Top module: `mw_eeprom_slave`

## Requirements
- R1: Serial clock and data activity counts only while `cs` is high; `do_oe` is low whenever `cs` is low and high while it is high.
- R2: Zeros on `di` before the first 1 are skipped; that first 1 is the start bit of the frame.
- R3: After the start bit, a 2-bit opcode and a 6-bit address arrive most significant bit first, each sampled on a rising `sk`; write data follows as 16 bits, bit 15 first.
- R4: With `pre` low, opcode 10 is a read: after the last address bit, `do_o` gives one 0, then bits 15 down to 0 of the addressed word, one per rising `sk`.
- R5: A read keeps going while `cs` stays high, word after word with no gap, and the address wraps from 63 to 0.
- R6: With `pre` low, opcode 01 writes one word; opcode 00 with address bits [5:4] = 11 enables writes, = 01 writes the data to every word, and = 00 disables writes.
- R7: Writes are disabled after reset. Enabling needs `pe` high. A single-word write or a whole-array write has effect only while writes are enabled and `pe` is high. Disabling works regardless of `pe`.
- R8: Programming starts when `cs` falls after a complete write frame and lasts PROG_CYC clocks. While a frame is open, `do_o` is 0 during programming and 1 once it is done. A frame that opens during programming is refused until `cs` rises again.
- R9: A word whose bit in `prot_map` is 1 keeps its value through any write.
- R10: With `pre` high, a completed header gives a one-cycle `pr_cmd_valid` with `pr_cmd_code` = {opcode, address[5:4]}, the 6-bit address and `pe`. The array is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| pre | input | 1 | Selects protect-unit instructions when high |
| pe | input | 1 | Allows write-type instructions when high |
| prot_map | input | 64 | Per-word write-protect flags from the protect unit |
| do_o | output | 1 | Serial data or ready/busy level to the host |
| do_oe | output | 1 | Output enable for `do_o` |
| pr_cmd_valid | output | 1 | One-cycle strobe for a protect-unit command |
| pr_cmd_code | output | 4 | Opcode and top two address bits of that command |
| pr_cmd_addr | output | 6 | Address field of that command |
| pr_cmd_pe | output | 1 | Level of `pe` when that command was decoded |

## Verification
The bench writes a distinct value to every address and reads the whole array back in one streaming frame that runs past word 63. A design that dropped a bit between words, or failed to wrap, would show shifted or wrong data. It opens a frame during programming and checks that the output reads busy and then ready, never array data; a design that accepted the frame would leak stored bits. Writes are tried without enable, with `pe` low, after disable and onto protected words, so a design that left out any of these gates changes a word the bench expects to stay put. Protect-select headers must give exactly one strobe with the right code and leave the array alone.

// File: rtl/mw_pkg.sv
package mw_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_HDR,
      S_DATA,
      S_READ,
      S_HOLD
   } fsm_t;

   typedef enum logic [1:0] {
      W_NONE,
      W_ONE,
      W_ALL
   } wkind_t;
endpackage

// File: rtl/mw_edge_sync.sv
module mw_edge_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mw_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES+1];
   logic [W-1:0] prev;

   assign pipe[0] = din;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[g+1] <= '0;
         else        pipe[g+1] <= pipe[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   assign lvl  = pipe[STAGES];
   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
endmodule

// File: rtl/mw_frame_rx.sv
module mw_frame_rx
   import mw_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_lvl,
   input  logic              cs_rise,
   input  logic              cs_fall,
   input  logic              sk_rise,
   input  logic              di,
   input  logic              pre,
   input  logic              pe,
   input  logic              busy,
   input  logic [DATA_W-1:0] rd_word,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              do_r,
   output logic              rd_active,
   output logic              stat_mode,
   output logic              wr_launch,
   output wkind_t            wr_kind,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              pr_valid,
   output logic [3:0]        pr_code,
   output logic [ADDR_W-1:0] pr_addr,
   output logic              pr_pe
);
   localparam int HW = 2 + ADDR_W;
   localparam int CW = $clog2((HW > DATA_W) ? HW : DATA_W) + 1;
   localparam int BW = $clog2(DATA_W);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("mw_frame_rx: ADDR_W must be at least 2");
      end
   endgenerate

   fsm_t              state;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     bitc;
   logic [HW-1:0]     hdr;
   logic [HW-1:0]     hdr_nx;
   logic [1:0]        op;
   logic [1:0]        amsb;
   logic [ADDR_W-1:0] adr;
   logic              wen;
   logic              armed;

   assign hdr_nx    = {hdr[HW-2:0], di};
   assign op        = hdr_nx[HW-1 -: 2];
   assign amsb      = hdr_nx[ADDR_W-1 -: 2];
   assign adr       = hdr_nx[ADDR_W-1:0];
   assign rd_active = (state == S_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         cnt       <= '0;
         bitc      <= '0;
         hdr       <= '0;
         wen       <= 1'b0;
         armed     <= 1'b0;
         stat_mode <= 1'b0;
         do_r      <= 1'b1;
         rd_addr   <= '0;
         wr_launch <= 1'b0;
         wr_kind   <= W_NONE;
         wr_addr   <= '0;
         wr_data   <= '0;
         pr_valid  <= 1'b0;
         pr_code   <= '0;
         pr_addr   <= '0;
         pr_pe     <= 1'b0;
      end else begin
         pr_valid  <= 1'b0;
         wr_launch <= 1'b0;
         if (cs_rise) begin
            state     <= S_IDLE;
            stat_mode <= busy;
            do_r      <= 1'b1;
            armed     <= 1'b0;
         end else if (cs_fall) begin
            wr_launch <= armed;
            armed     <= 1'b0;
            state     <= S_IDLE;
            do_r      <= 1'b1;
         end else if (cs_lvl && sk_rise && !stat_mode) begin
            unique case (state)
               S_IDLE: begin
                  if (di) begin
                     state <= S_HDR;
                     cnt   <= '0;
                  end
               end
               S_HDR: begin
                  hdr <= hdr_nx;
                  cnt <= cnt + 1'b1;
                  if (cnt == CW'(HW - 1)) begin
                     state <= S_HOLD;
                     cnt   <= '0;
                     if (pre) begin
                        pr_valid <= 1'b1;
                        pr_code  <= {op, amsb};
                        pr_addr  <= adr;
                        pr_pe    <= pe;
                     end else begin
                        unique case (op)
                           2'b10: begin
                              state   <= S_READ;
                              rd_addr <= adr;
                              bitc    <= '0;
                              do_r    <= 1'b0;
                           end
                           2'b01: begin
                              if (wen && pe) begin
                                 state   <= S_DATA;
                                 wr_kind <= W_ONE;
                                 wr_addr <= adr;
                              end
                           end
                           2'b00: begin
                              if (amsb == 2'b11 && pe) wen <= 1'b1;
                              if (amsb == 2'b00)       wen <= 1'b0;
                              if (amsb == 2'b01 && wen && pe) begin
                                 state   <= S_DATA;
                                 wr_kind <= W_ALL;
                              end
                           end
                           default: ;
                        endcase
                     end
                  end
               end
               S_DATA: begin
                  wr_data <= {wr_data[DATA_W-2:0], di};
                  cnt     <= cnt + 1'b1;
                  if (cnt == CW'(DATA_W - 1)) begin
                     state <= S_HOLD;
                     armed <= 1'b1;
                  end
               end
               S_READ: begin
                  do_r <= rd_word[BW'(DATA_W - 1) - bitc];
                  if (bitc == BW'(DATA_W - 1)) begin
                     bitc    <= '0;
                     rd_addr <= rd_addr + 1'b1;
                  end else begin
                     bitc <= bitc + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   p_pr_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pr_valid |=> !pr_valid);

   p_stat_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_mode |-> !rd_active);

   p_launch_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_launch |-> $past(cs_fall));
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer
   import mw_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 16,
   parameter int PROG_CYC = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  wkind_t            kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              busy,
   output logic              commit,
   output wkind_t            c_kind,
   output logic [ADDR_W-1:0] c_addr,
   output logic [DATA_W-1:0] c_data
);
   localparam int TW = $clog2(PROG_CYC + 1);

   generate
      if (PROG_CYC < 1) begin : g_bad_cyc
         $error("mw_prog_timer: PROG_CYC must be at least 1");
      end
   endgenerate

   logic [TW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         commit <= 1'b0;
         remain <= '0;
         c_kind <= W_NONE;
         c_addr <= '0;
         c_data <= '0;
      end else begin
         commit <= 1'b0;
         if (launch && !busy) begin
            busy   <= 1'b1;
            remain <= TW'(PROG_CYC - 1);
            c_kind <= kind;
            c_addr <= addr;
            c_data <= data;
         end else if (busy) begin
            if (remain == '0) begin
               busy   <= 1'b0;
               commit <= 1'b1;
            end else begin
               remain <= remain - 1'b1;
            end
         end
      end
   end

   p_commit_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (!busy && $past(busy)));
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
   import mw_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int PROG_CYC    = 200,
   parameter int SYNC_STAGES = 2,
   localparam int WORDS      = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              sk,
   input  logic              di,
   input  logic              pre,
   input  logic              pe,
   input  logic [WORDS-1:0]  prot_map,
   output logic              do_o,
   output logic              do_oe,
   output logic              pr_cmd_valid,
   output logic [3:0]        pr_cmd_code,
   output logic [ADDR_W-1:0] pr_cmd_addr,
   output logic              pr_cmd_pe
);
   logic [4:0] s_lvl, s_rise, s_fall;

   mw_edge_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({pre, pe, di, sk, cs}),
      .lvl  (s_lvl),
      .rise (s_rise),
      .fall (s_fall)
   );

   logic              busy, commit, do_r, rd_active, stat_mode, wr_launch;
   wkind_t            wr_kind, c_kind;
   logic [ADDR_W-1:0] rd_addr, wr_addr, c_addr;
   logic [DATA_W-1:0] wr_data, c_data, rd_word;
   logic [DATA_W-1:0] mem [WORDS];

   assign rd_word = mem[rd_addr];

   mw_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_lvl   (s_lvl[0]),
      .cs_rise  (s_rise[0]),
      .cs_fall  (s_fall[0]),
      .sk_rise  (s_rise[1]),
      .di       (s_lvl[2]),
      .pre      (s_lvl[4]),
      .pe       (s_lvl[3]),
      .busy     (busy),
      .rd_word  (rd_word),
      .rd_addr  (rd_addr),
      .do_r     (do_r),
      .rd_active(rd_active),
      .stat_mode(stat_mode),
      .wr_launch(wr_launch),
      .wr_kind  (wr_kind),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pr_valid (pr_cmd_valid),
      .pr_code  (pr_cmd_code),
      .pr_addr  (pr_cmd_addr),
      .pr_pe    (pr_cmd_pe)
   );

   mw_prog_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .launch(wr_launch),
      .kind  (wr_kind),
      .addr  (wr_addr),
      .data  (wr_data),
      .busy  (busy),
      .commit(commit),
      .c_kind(c_kind),
      .c_addr(c_addr),
      .c_data(c_data)
   );

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[w] <= '0;
         end else if (commit && !prot_map[w] &&
                      (c_kind == W_ALL || (c_kind == W_ONE && c_addr == ADDR_W'(w)))) begin
            mem[w] <= c_data;
         end
      end

      p_write_only_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(mem[w]) |-> $past(commit));

      p_protected_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
         prot_map[w] |=> $stable(mem[w]));
   end

   assign do_o  = (stat_mode || busy) ? ~busy : do_r;
   assign do_oe = s_lvl[0];

   p_deselect_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !s_lvl[0] |=> !rd_active);
endmodule

// File: tb/mw_eeprom_slave_test.sv
module mw_eeprom_slave_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0, sk = 1'b0, di = 1'b0, pre = 1'b0, pe = 1'b0;
   logic [63:0] prot_map = '0;
   logic        do_o, do_oe, pr_cmd_valid, pr_cmd_pe;
   logic [3:0]  pr_cmd_code;
   logic [5:0]  pr_cmd_addr;

   int checks = 0;
   int errors = 0;
   int pr_n = 0;
   logic [3:0] pr_code_c;
   logic [5:0] pr_addr_c;
   logic       pr_pe_c;

   always #2 clk = ~clk;

   mw_eeprom_slave uut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .pre(pre), .pe(pe),
      .prot_map(prot_map), .do_o(do_o), .do_oe(do_oe),
      .pr_cmd_valid(pr_cmd_valid), .pr_cmd_code(pr_cmd_code),
      .pr_cmd_addr(pr_cmd_addr), .pr_cmd_pe(pr_cmd_pe)
   );

   always @(posedge clk) begin
      if (pr_cmd_valid) begin
         pr_n      <= pr_n + 1;
         pr_code_c <= pr_cmd_code;
         pr_addr_c <= pr_cmd_addr;
         pr_pe_c   <= pr_cmd_pe;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input int a);
      return 16'((a * 1031) ^ 'h3C5A ^ (a << 9));
   endfunction

   task automatic bitx(input logic b, output logic o);
      di = b;
      repeat (8) @(negedge clk);
      sk = 1'b1;
      repeat (8) @(negedge clk);
      sk = 1'b0;
      o = do_o;
   endtask

   task automatic send(input logic [31:0] v, input int n);
      logic o;
      for (int i = n - 1; i >= 0; i--) bitx(v[i], o);
   endtask

   task automatic hdr(input logic [1:0] op, input logic [5:0] a, output logic o);
      bitx(1'b1, o);
      send(32'(op), 2);
      for (int i = 5; i >= 0; i--) bitx(a[i], o);
   endtask

   task automatic begin_f();
      cs = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic end_f();
      cs = 1'b0;
      di = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic wait_ready();
      begin_f();
      for (int i = 0; i < 3000 && do_o !== 1'b1; i++) @(negedge clk);
      end_f();
   endtask

   task automatic cmd(input logic [1:0] op, input logic [5:0] a);
      logic o;
      begin_f();
      hdr(op, a, o);
      end_f();
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      logic o;
      begin_f();
      hdr(2'b01, a, o);
      send(32'(d), 16);
      end_f();
      wait_ready();
   endtask

   task automatic wrall(input logic [15:0] d);
      logic o;
      begin_f();
      hdr(2'b00, 6'b010000, o);
      send(32'(d), 16);
      end_f();
      wait_ready();
   endtask

   task automatic rd_word(output logic [15:0] d);
      logic o;
      d = '0;
      for (int i = 0; i < 16; i++) begin
         bitx(1'b0, o);
         d = {d[14:0], o};
      end
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] d, output logic dummy);
      begin_f();
      hdr(2'b10, a, dummy);
      rd_word(d);
      end_f();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic o;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      check("R1 oe low at reset", 32'(do_oe), 32'd0);

      rd(6'd3, d, o);
      check("R4 dummy bit", 32'(o), 32'd0);
      check("R4 reset word", 32'(d), 32'd0);

      pe = 1'b1;
      wr(6'd5, 16'h1111);
      rd(6'd5, d, o);
      check("R7 write before enable", 32'(d), 32'd0);

      pe = 1'b0;
      cmd(2'b00, 6'b110000);
      pe = 1'b1;
      wr(6'd5, 16'h2222);
      rd(6'd5, d, o);
      check("R7 enable with pe low", 32'(d), 32'd0);

      cmd(2'b00, 6'b110000);
      begin_f();
      send(32'd0, 3);
      hdr(2'b01, 6'd5, o);
      send(32'hA5C3, 16);
      end_f();
      check("R1 oe low after frame", 32'(do_oe), 32'd0);
      begin_f();
      check("R8 busy level", 32'(do_o), 32'd0);
      check("R1 oe high with cs", 32'(do_oe), 32'd1);
      end_f();
      wait_ready();
      rd(6'd5, d, o);
      check("R2 R3 leading zeros then write", 32'(d), 32'hA5C3);

      // frame opened during programming is refused
      begin_f();
      hdr(2'b01, 6'd6, o);
      send(32'h0000, 16);
      end_f();
      begin_f();
      hdr(2'b10, 6'd5, o);
      check("R8 refused frame shows busy", 32'(o), 32'd0);
      send(32'd0, 10);
      bitx(1'b0, o);
      check("R8 refused frame shows ready", 32'(o), 32'd1);
      end_f();

      pe = 1'b0;
      wr(6'd5, 16'h7777);
      rd(6'd5, d, o);
      check("R7 write with pe low", 32'(d), 32'hA5C3);
      pe = 1'b1;

      // sweep every address, then read all in one frame past the wrap
      for (int a = 0; a < 64; a++) wr(6'(a), pat(a));
      begin_f();
      hdr(2'b10, 6'd0, o);
      for (int a = 0; a < 65; a++) begin
         rd_word(d);
         check("R5 R6 sequential sweep", 32'(d), 32'(pat(a % 64)));
      end
      end_f();

      begin_f();
      hdr(2'b10, 6'd62, o);
      for (int k = 0; k < 3; k++) begin
         rd_word(d);
         check("R5 wrap from 62", 32'(d), 32'(pat((62 + k) % 64)));
      end
      end_f();

      prot_map[9] = 1'b1;
      wr(6'd9, 16'hBEEF);
      rd(6'd9, d, o);
      check("R9 protected single write", 32'(d), 32'(pat(9)));
      wrall(16'h1234);
      begin_f();
      hdr(2'b10, 6'd0, o);
      for (int a = 0; a < 64; a++) begin
         rd_word(d);
         check("R6 R9 write-all", 32'(d), (a == 9) ? 32'(pat(9)) : 32'h1234);
      end
      end_f();

      cmd(2'b00, 6'b000000);
      wr(6'd2, 16'hFFFF);
      rd(6'd2, d, o);
      check("R7 write after disable", 32'(d), 32'h1234);

      pre = 1'b1;
      cmd(2'b11, 6'b111111);
      check("R10 pulse count", 32'(pr_n), 32'd1);
      check("R10 code", 32'(pr_code_c), 32'hF);
      check("R10 addr", 32'(pr_addr_c), 32'd63);
      check("R10 pe", 32'(pr_pe_c), 32'd1);
      pe = 1'b0;
      cmd(2'b01, 6'd12);
      check("R10 second pulse", 32'(pr_n), 32'd2);
      check("R10 code write", 32'(pr_code_c), 32'h4);
      check("R10 addr write", 32'(pr_addr_c), 32'd12);
      check("R10 pe low", 32'(pr_pe_c), 32'd0);
      pre = 1'b0;
      rd(6'd12, d, o);
      check("R10 array untouched", 32'(d), 32'h1234);

      // sk/di activity with cs low has no effect
      for (int i = 0; i < 9; i++) bitx(1'b1, o);
      check("R1 oe low while deselected", 32'(do_oe), 32'd0);
      rd(6'd4, d, o);
      check("R1 read after deselected activity", 32'(d), 32'h1234);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule